// File: doc/BRIEF.md
# Extended Audio Control Register File

This block is the codec-side register file for extended audio control. It holds one control/status word plus two PCM sample-rate registers, one for the playback converter (DAC) and one for the capture converter (ADC). The rest of the codec reads the stored values from dedicated outputs: the variable-rate enable, the digital-audio-output enable, a two-bit slot-assignment field and both rate codes.

Software reaches the block over a simple register bus with an address, write data, a write strobe, a read strobe and registered read data. Bit 10 of the control word is not stored. It reflects a configuration-valid status flag that comes from outside the block. While variable rate is off, both rate registers are pinned to the 48 kHz code BB80h. A write that turns variable rate off reloads that code into both rate registers on the same clock edge.

Top module: `xaud_ctl_regs`

## Requirements
- R1: Synchronous active-high reset leaves the stored control bits at 0, both rate registers at BB80h and read data at 0000h; a read of the control word (index 2Ah) with the configuration-valid input at 1 then returns 0400h.
- R2: A write to index 2Ah stores bit 0 as the variable-rate enable, bit 2 as the digital-audio-output enable and bits 5:4 as the slot-assignment field; the matching outputs change on the clock edge that takes the write, and a read of 2Ah returns those bits in the same positions.
- R3: Bit 10 of the control word reads as the configuration-valid input (1 = valid); writing bit 10 changes nothing.
- R4: Bits 15:11, 9:6, 3 and 1 of the control word always read as 0, even after a write of ones.
- R5: While variable-rate enable is 1, a write to index 2Ch loads the DAC rate and a write to index 32h loads the ADC rate; each value appears on its rate output after the write edge and reads back unchanged.
- R6: While variable-rate enable is 0, both rate outputs are BB80h, writes to 2Ch and 32h are discarded, and reads of them return BB80h.
- R7: A control write with bit 0 at 0 loads BB80h into both rate registers on the same clock edge that clears the enable.
- R8: An address other than 2Ah, 2Ch and 32h reads as 0000h, and a write to it changes no output and no register.
- R9: Read data updates one edge after a cycle with the read strobe high and holds while the strobe is low; a read and a write to the same index in one cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Register index |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| cfg_valid_i | input | 1 | Configuration-valid status flag, shown at control bit 10 |
| vra_en_o | output | 1 | Variable-rate enable |
| dig_out_en_o | output | 1 | Digital-audio-output enable |
| slot_sel_o | output | 2 | Slot-assignment field |
| dac_rate_o | output | 16 | DAC sample-rate code |
| adc_rate_o | output | 16 | ADC sample-rate code |

## Verification
Two of the block's functions can land on the same clock edge: a read of a register and a write to that same register. The two cases that matter are a rate register being rewritten while it is read, and the control word clearing variable rate while it is read. The bench raises both strobes in one cycle for each case. The read data must show the value from before the write. A follow-up read must show the new value, or BB80h in both rate registers once variable rate has been cleared.

// File: rtl/xaud_pkg.sv
package xaud_pkg;
  localparam int unsigned VRA_BIT  = 0;
  localparam int unsigned DOUT_BIT = 2;
  localparam int unsigned SLOT_LO  = 4;
  localparam int unsigned SLOT_W   = 2;
  localparam int unsigned CFG_BIT  = 10;
  localparam int unsigned NUM_RATE = 2;
  localparam int unsigned RATE_DAC = 0;
  localparam int unsigned RATE_ADC = 1;
endpackage

// File: rtl/xaud_addr_dec.sv
module xaud_addr_dec #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned N_RATE = 2,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h2A,
  parameter logic [N_RATE-1:0][ADDR_W-1:0] RATE_IDX = {7'h32, 7'h2C}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_ctrl_o,
  output logic [N_RATE-1:0] hit_rate_o
);
  assign hit_ctrl_o = (addr_i == CTRL_IDX);

  for (genvar g = 0; g < N_RATE; g++) begin : g_cmp
    assign hit_rate_o[g] = (addr_i == RATE_IDX[g]);
  end
endmodule

// File: rtl/xaud_ctrl_word.sv
module xaud_ctrl_word
  import xaud_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              vra_o,
  output logic              dout_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              clr_o
);
  localparam logic [DATA_W-1:0] WR_MASK =
    DATA_W'((1 << VRA_BIT) | (1 << DOUT_BIT) | (((1 << SLOT_W) - 1) << SLOT_LO));

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr_i) begin
      word_q <= wdata_i & WR_MASK;
    end
  end

  // a write whose enable bit is 0 reloads the rate registers this edge
  assign clr_o  = wr_i & ~wdata_i[VRA_BIT];
  assign word_o = word_q;
  assign vra_o  = word_q[VRA_BIT];
  assign dout_o = word_q[DOUT_BIT];
  assign slot_o = word_q[SLOT_LO +: SLOT_W];
endmodule

// File: rtl/xaud_rate_reg.sv
module xaud_rate_reg #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = 16'hBB80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic              force_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rate_o
);
  always_ff @(posedge clk) begin
    if (rst || force_i) begin
      rate_o <= RST_VAL;
    end else if (wr_i && en_i) begin
      rate_o <= wdata_i;
    end
  end
endmodule

// File: rtl/xaud_ctl_regs.sv
module xaud_ctl_regs
  import xaud_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h2A,
  parameter logic [ADDR_W-1:0] DAC_IDX  = 7'h2C,
  parameter logic [ADDR_W-1:0] ADC_IDX  = 7'h32,
  parameter logic [DATA_W-1:0] RATE_RST = 16'hBB80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              cfg_valid_i,
  output logic              vra_en_o,
  output logic              dig_out_en_o,
  output logic [SLOT_W-1:0] slot_sel_o,
  output logic [DATA_W-1:0] dac_rate_o,
  output logic [DATA_W-1:0] adc_rate_o
);
  localparam logic [NUM_RATE-1:0][ADDR_W-1:0] RATE_IDX = {ADC_IDX, DAC_IDX};

  logic                             hit_ctrl;
  logic [NUM_RATE-1:0]              hit_rate;
  logic [DATA_W-1:0]                ctrl_word;
  logic                             clr;
  logic [NUM_RATE-1:0][DATA_W-1:0]  rate_q;
  logic [DATA_W-1:0]                status_word;
  logic [DATA_W-1:0]                rd_mux;

  xaud_addr_dec #(
    .ADDR_W(ADDR_W), .N_RATE(NUM_RATE), .CTRL_IDX(CTRL_IDX), .RATE_IDX(RATE_IDX)
  ) u_dec (
    .addr_i(addr), .hit_ctrl_o(hit_ctrl), .hit_rate_o(hit_rate)
  );

  xaud_ctrl_word #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(wr_en & hit_ctrl), .wdata_i(wdata),
    .word_o(ctrl_word), .vra_o(vra_en_o), .dout_o(dig_out_en_o),
    .slot_o(slot_sel_o), .clr_o(clr)
  );

  for (genvar g = 0; g < NUM_RATE; g++) begin : g_rate
    xaud_rate_reg #(.DATA_W(DATA_W), .RST_VAL(RATE_RST)) u_rate (
      .clk(clk), .rst(rst), .wr_i(wr_en & hit_rate[g]), .en_i(vra_en_o),
      .force_i(clr), .wdata_i(wdata), .rate_o(rate_q[g])
    );
  end

  assign dac_rate_o = rate_q[RATE_DAC];
  assign adc_rate_o = rate_q[RATE_ADC];

  always_comb begin
    status_word = '0;
    status_word[CFG_BIT] = cfg_valid_i;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_word | status_word;
    for (int i = 0; i < NUM_RATE; i++) begin
      if (hit_rate[i]) rd_mux = rate_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/xaud_ctl_chk.sv
module xaud_ctl_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h2A,
  parameter logic [ADDR_W-1:0] DAC_IDX  = 7'h2C,
  parameter logic [ADDR_W-1:0] ADC_IDX  = 7'h32,
  parameter logic [DATA_W-1:0] RATE_RST = 16'hBB80
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              cfg_valid_i,
  input logic              vra_en_o,
  input logic [DATA_W-1:0] dac_rate_o,
  input logic [DATA_W-1:0] adc_rate_o
);
  localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(16'h0435);

  logic unmapped;
  assign unmapped = (addr != CTRL_IDX) && (addr != DAC_IDX) && (addr != ADC_IDX);

  p_rate_pinned_r6: assert property (@(posedge clk) disable iff (rst)
    !vra_en_o |-> (dac_rate_o == RATE_RST) && (adc_rate_o == RATE_RST));

  p_clear_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_IDX && !wdata[0]) |=>
      (dac_rate_o == RATE_RST) && (adc_rate_o == RATE_RST) && !vra_en_o);

  p_locked_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == DAC_IDX && !vra_en_o) |=> $stable(dac_rate_o));

  p_cfg_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CTRL_IDX) |=> rdata[10] == $past(cfg_valid_i));

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CTRL_IDX) |=> (rdata & ~LIVE_MASK) == '0);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |=> rdata == '0);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind xaud_ctl_regs xaud_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX),
  .DAC_IDX(DAC_IDX), .ADC_IDX(ADC_IDX), .RATE_RST(RATE_RST)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .cfg_valid_i(cfg_valid_i),
  .vra_en_o(vra_en_o), .dac_rate_o(dac_rate_o), .adc_rate_o(adc_rate_o)
);

// File: tb/sim_xaud_ctl_regs.sv
`timescale 1ns/1ps
module sim_xaud_ctl_regs;
  localparam logic [6:0]  A_CTRL = 7'h2A;
  localparam logic [6:0]  A_DAC  = 7'h2C;
  localparam logic [6:0]  A_ADC  = 7'h32;
  localparam logic [15:0] R48    = 16'hBB80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;
  logic        cfg_valid_i = 1'b1;
  logic        vra_en_o;
  logic        dig_out_en_o;
  logic [1:0]  slot_sel_o;
  logic [15:0] dac_rate_o;
  logic [15:0] adc_rate_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xaud_ctl_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cfg_valid_i(cfg_valid_i),
    .vra_en_o(vra_en_o), .dig_out_en_o(dig_out_en_o), .slot_sel_o(slot_sel_o),
    .dac_rate_o(dac_rate_o), .adc_rate_o(adc_rate_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 rdata after reset", rdata, 16'h0000);
    chk("R1 vra", {15'b0, vra_en_o}, 16'h0);
    chk("R1 dout", {15'b0, dig_out_en_o}, 16'h0);
    chk("R1 slot", {14'b0, slot_sel_o}, 16'h0);
    chk("R1 dac rate", dac_rate_o, R48);
    chk("R1 adc rate", adc_rate_o, R48);
    cfg_valid_i = 1'b1;
    rd(A_CTRL, v);
    chk("R1 control default", v, 16'h0400);
  endtask

  task automatic t_ctrl_write;
    logic [15:0] v;
    wr(A_CTRL, 16'h0035);
    chk("R2 vra set", {15'b0, vra_en_o}, 16'h1);
    chk("R2 dout set", {15'b0, dig_out_en_o}, 16'h1);
    chk("R2 slot 3", {14'b0, slot_sel_o}, 16'h3);
    rd(A_CTRL, v);
    chk("R2 readback 0035", v, 16'h0435);
    wr(A_CTRL, 16'h0021);
    chk("R2 dout clear", {15'b0, dig_out_en_o}, 16'h0);
    chk("R2 slot 2", {14'b0, slot_sel_o}, 16'h2);
    rd(A_CTRL, v);
    chk("R2 readback 0021", v, 16'h0421);
  endtask

  task automatic t_ro_flag;
    logic [15:0] v;
    cfg_valid_i = 1'b0;
    wr(A_CTRL, 16'h0401);
    rd(A_CTRL, v);
    chk("R3 write of bit10 ignored", v, 16'h0001);
    cfg_valid_i = 1'b1;
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, v);
    chk("R3 bit10 follows flag", v, 16'h0401);
  endtask

  task automatic t_reserved;
    logic [15:0] v;
    cfg_valid_i = 1'b0;
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, v);
    chk("R4 reserved read zero", v, 16'h0035);
    cfg_valid_i = 1'b1;
  endtask

  task automatic t_rate_write;
    logic [15:0] v;
    wr(A_DAC, 16'h5622);
    wr(A_ADC, 16'h1F40);
    chk("R5 dac output", dac_rate_o, 16'h5622);
    chk("R5 adc output", adc_rate_o, 16'h1F40);
    rd(A_DAC, v);
    chk("R5 dac readback", v, 16'h5622);
    rd(A_ADC, v);
    chk("R5 adc readback", v, 16'h1F40);
  endtask

  task automatic t_clear_vra;
    wr(A_CTRL, 16'h0004);
    chk("R7 vra cleared", {15'b0, vra_en_o}, 16'h0);
    chk("R7 dac reloaded", dac_rate_o, R48);
    chk("R7 adc reloaded", adc_rate_o, R48);
  endtask

  task automatic t_rate_locked;
    logic [15:0] v;
    wr(A_DAC, 16'h1234);
    wr(A_ADC, 16'h4321);
    chk("R6 dac locked", dac_rate_o, R48);
    chk("R6 adc locked", adc_rate_o, R48);
    rd(A_DAC, v);
    chk("R6 dac read 48k", v, R48);
    rd(A_ADC, v);
    chk("R6 adc read 48k", v, R48);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    wr(A_CTRL, 16'h0015);
    wr(A_DAC, 16'h7D00);
    wr(7'h30, 16'hFFFF);
    wr(7'h2E, 16'h0000);
    rd(7'h30, v);
    chk("R8 unmapped 30 reads 0", v, 16'h0000);
    rd(7'h2E, v);
    chk("R8 unmapped 2E reads 0", v, 16'h0000);
    rd(A_CTRL, v);
    chk("R8 control untouched", v, 16'h0415);
    chk("R8 dac untouched", dac_rate_o, 16'h7D00);
    chk("R8 adc untouched", adc_rate_o, R48);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    wr(A_DAC, 16'hAC44);
    @(negedge clk);
    addr = A_DAC; wdata = 16'h3E80; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 same-cycle read old rate", rdata, 16'hAC44);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", rdata, 16'hAC44);
    rd(A_DAC, v);
    chk("R9 new rate visible", v, 16'h3E80);
    @(negedge clk);
    addr = A_CTRL; wdata = 16'h0000; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 same-cycle read old control", rdata, 16'h0415);
    chk("R7 clear during read", dac_rate_o, R48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_write();
    t_ro_flag();
    t_reserved();
    t_rate_write();
    t_clear_vra();
    t_rate_locked();
    t_unmapped();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule